// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block decides which NaN a single-precision fused multiply-add `(a*b)+c` returns once the datapath has found that at least one operand is a NaN, or that the product is zero times infinity. It takes the three operands as one stream beat on a valid/ready input. With each beat come a flag from the caller marking the zero-times-infinity product and three plain configuration pins. The first pin selects one of four propagation policies. The second forces the default NaN. The third picks between the normal encoding (fraction MSB set means quiet) and the legacy encoding (fraction MSB set means signaling).

For each accepted beat the block emits a 2-bit selection code (0 = a, 1 = b, 2 = c, 3 = default NaN) and the final 32-bit result. The result is the chosen operand with any signaling NaN made quiet. An invalid-operation flag stays set once raised. The output is a single register stage with valid/ready. A beat is accepted when `in_valid` is high and the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` reaches `in_ready` without delay. A held result stays unchanged until it is taken.

Top module: `nan_fma_select`

## Requirements
- R1: In normal encoding a value is a NaN only when its exponent field (bits 30:23) is all ones and its fraction is nonzero; fraction bit 22 set marks it quiet, clear marks it signaling. Infinity (exponent all ones, fraction zero) is not a NaN.
- R2: In legacy encoding (`cfg_legacy`=1) the meaning of fraction bit 22 is inverted: set marks signaling, clear with the other fraction bits nonzero marks quiet.
- R3: `inv_flag` is set by any accepted beat in which a, b or c is a signaling NaN, or in which the policy raises invalid for zero times infinity. Once set it stays set until reset.
- R4: Policy 0 with `in_infzero` set and c a quiet NaN gives code 3 and raises invalid. With c a signaling NaN the beat instead follows the R5 order.
- R5: Otherwise policy 0 picks the first match in this list: c signaling, a signaling, b signaling, c quiet, a quiet. If none matches it picks b.
- R6: Policy 1 with `in_infzero` set gives code 3 and raises invalid. Without it, signaling NaNs rank before quiet ones. Within each class the operand order is a, b, c in legacy encoding and c, a, b in normal encoding. If none matches the last operand of that order is picked.
- R7: Policy 2 with `in_infzero` set gives code 2 and raises invalid. Otherwise it picks a if a is any NaN, then c if c is any NaN, else b.
- R8: Policy 3 picks a if a is any NaN, then b if b is any NaN, else c. `in_infzero` has no effect.
- R9: For codes 0 to 2 the result is the chosen operand. A signaling NaN gets bit 22 set in normal encoding and is replaced by the default NaN in legacy encoding. Code 3 gives the default NaN, which is 0x7FC00000 in normal encoding and 0x7FBFFFFF in legacy encoding.
- R10: With `cfg_dnan` set the result is the default NaN of the current encoding. The code output and the invalid raise are those of the normal selection.
- R11: `in_ready` equals `!out_valid || out_ready`. An accepted beat appears on the outputs after the next rising edge. While `out_valid && !out_ready`, the outputs hold.
- R12: After reset `out_valid` and `inv_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_a | input | 32 | Multiplicand a |
| in_b | input | 32 | Multiplier b |
| in_c | input | 32 | Addend c |
| in_infzero | input | 1 | Product a*b is zero times infinity |
| cfg_policy | input | 2 | Propagation policy 0..3 |
| cfg_dnan | input | 1 | Force the default NaN as result |
| cfg_legacy | input | 1 | Legacy NaN encoding |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_code | output | 2 | Selection: 0 a, 1 b, 2 c, 3 default NaN |
| out_res | output | 32 | Final NaN result |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench builds the block with its default exponent and fraction widths of 8 and 23. With these widths the exact default-NaN words of both encodings can be checked, as can the quieting bit at position 22. Infinity can be placed next to real NaNs, which tests the boundary of the classifier. A random phase mixes all four policies and both encodings with stalls on `out_ready`, which exercises the held-output and same-cycle drain paths.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;

  typedef enum logic [1:0] {
    POL_A   = 2'd0,
    POL_B   = 2'd1,
    POL_C   = 2'd2,
    POL_DEF = 2'd3
  } nan_pol_e;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_DFLT = 2'd3
  } nan_sel_e;

  typedef struct packed {
    logic qnan;
    logic snan;
  } nan_cls_t;

endpackage

// File: rtl/fmanan_classify.sv
module fmanan_classify
  import fmanan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  input  logic                    legacy,
  output nan_cls_t                cls
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic exp_ones, top_bit, low_nz;

  always_comb begin
    exp_ones = &mag[MAG_W-1:FRAC_W];
    top_bit  = mag[FRAC_W-1];
    low_nz   = |mag[FRAC_W-2:0];
    if (legacy) begin
      cls.snan = exp_ones & top_bit;
      cls.qnan = exp_ones & ~top_bit & low_nz;
    end else begin
      cls.qnan = exp_ones & top_bit;
      cls.snan = exp_ones & ~top_bit & low_nz;
    end
  end
endmodule

// File: rtl/fmanan_pick.sv
module fmanan_pick
  import fmanan_pkg::*;
(
  input  nan_cls_t cls_a,
  input  nan_cls_t cls_b,
  input  nan_cls_t cls_c,
  input  logic     infzero,
  input  nan_pol_e policy,
  input  logic     legacy,
  output nan_sel_e sel,
  output logic     iz_raise
);
  logic nan_a, nan_b, nan_c;

  assign nan_a = cls_a.qnan | cls_a.snan;
  assign nan_b = cls_b.qnan | cls_b.snan;
  assign nan_c = cls_c.qnan | cls_c.snan;

  always_comb begin
    sel      = SEL_B;
    iz_raise = 1'b0;
    case (policy)
      POL_A: begin
        if (infzero && cls_c.qnan) begin
          sel      = SEL_DFLT;
          iz_raise = 1'b1;
        end
        else if (cls_c.snan) sel = SEL_C;
        else if (cls_a.snan) sel = SEL_A;
        else if (cls_b.snan) sel = SEL_B;
        else if (cls_c.qnan) sel = SEL_C;
        else if (cls_a.qnan) sel = SEL_A;
        else                 sel = SEL_B;
      end
      POL_B: begin
        if (infzero) begin
          sel      = SEL_DFLT;
          iz_raise = 1'b1;
        end else if (legacy) begin
          if      (cls_a.snan) sel = SEL_A;
          else if (cls_b.snan) sel = SEL_B;
          else if (cls_c.snan) sel = SEL_C;
          else if (cls_a.qnan) sel = SEL_A;
          else if (cls_b.qnan) sel = SEL_B;
          else                 sel = SEL_C;
        end else begin
          if      (cls_c.snan) sel = SEL_C;
          else if (cls_a.snan) sel = SEL_A;
          else if (cls_b.snan) sel = SEL_B;
          else if (cls_c.qnan) sel = SEL_C;
          else if (cls_a.qnan) sel = SEL_A;
          else                 sel = SEL_B;
        end
      end
      POL_C: begin
        if (infzero) begin
          sel      = SEL_C;
          iz_raise = 1'b1;
        end
        else if (nan_a) sel = SEL_A;
        else if (nan_c) sel = SEL_C;
        else            sel = SEL_B;
      end
      default: begin
        if      (nan_a) sel = SEL_A;
        else if (nan_b) sel = SEL_B;
        else            sel = SEL_C;
      end
    endcase
  end
endmodule

// File: rtl/fmanan_quiet.sv
module fmanan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  input  logic                  is_snan,
  input  logic                  legacy,
  input  logic [EXP_W+FRAC_W:0] dflt,
  output logic [EXP_W+FRAC_W:0] res
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QBIT = {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    if (!is_snan)    res = opnd;
    else if (legacy) res = dflt;
    else             res = opnd | QBIT;
  end
endmodule

// File: rtl/nan_fma_select.sv
module nan_fma_select
  import fmanan_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         in_infzero,
  input  logic [1:0]   cfg_policy,
  input  logic         cfg_dnan,
  input  logic         cfg_legacy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [1:0]   out_code,
  output logic [W-1:0] out_res,
  output logic         inv_flag
);
  localparam int NOPS = 3;

  logic [W-1:0] ops [NOPS];
  nan_cls_t     cls [NOPS];
  logic [W-1:0] dflt_nan;
  nan_sel_e     sel;
  logic         iz_raise;
  logic         any_snan;
  logic [W-1:0] chosen;
  logic         chosen_snan;
  logic [W-1:0] quieted;
  logic [W-1:0] final_res;
  logic         accept;

  assign ops[0] = in_a;
  assign ops[1] = in_b;
  assign ops[2] = in_c;

  // default NaN: positive, exponent all ones, quiet marker per encoding
  assign dflt_nan = {1'b0, {EXP_W{1'b1}}, ~cfg_legacy, {(FRAC_W-1){cfg_legacy}}};

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fmanan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag    (ops[gi][W-2:0]),
      .legacy (cfg_legacy),
      .cls    (cls[gi])
    );
  end

  assign any_snan = cls[0].snan | cls[1].snan | cls[2].snan;

  fmanan_pick u_pick (
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .cls_c    (cls[2]),
    .infzero  (in_infzero),
    .policy   (nan_pol_e'(cfg_policy)),
    .legacy   (cfg_legacy),
    .sel      (sel),
    .iz_raise (iz_raise)
  );

  always_comb begin
    case (sel)
      SEL_A:   begin chosen = ops[0]; chosen_snan = cls[0].snan; end
      SEL_B:   begin chosen = ops[1]; chosen_snan = cls[1].snan; end
      SEL_C:   begin chosen = ops[2]; chosen_snan = cls[2].snan; end
      default: begin chosen = dflt_nan; chosen_snan = 1'b0; end
    endcase
  end

  fmanan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .opnd    (chosen),
    .is_snan (chosen_snan),
    .legacy  (cfg_legacy),
    .dflt    (dflt_nan),
    .res     (quieted)
  );

  // default-NaN override comes after selection; raise is unaffected
  assign final_res = (cfg_dnan || sel == SEL_DFLT) ? dflt_nan : quieted;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= 2'd0;
      out_res   <= '0;
      inv_flag  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_code  <= sel;
        out_res   <= final_res;
        inv_flag  <= inv_flag | any_snan | iz_raise;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fmanan_chk.sv
module fmanan_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_infzero,
  input logic [1:0]   cfg_policy,
  input logic         cfg_dnan,
  input logic         cfg_legacy,
  input logic         out_valid,
  input logic         out_ready,
  input logic [1:0]   out_code,
  input logic [W-1:0] out_res,
  input logic         inv_flag
);
  localparam logic [W-1:0] DN_NORMAL = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic took;
  assign took = in_valid && in_ready;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_code));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_flag |=> inv_flag);

  p_dnan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    took && cfg_dnan && !cfg_legacy |=> out_res == DN_NORMAL);

  p_polb_iz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    took && cfg_policy == 2'd1 && in_infzero |=> out_code == 2'd3 && inv_flag);

  p_polc_iz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    took && cfg_policy == 2'd2 && in_infzero |=> out_code == 2'd2 && inv_flag);

  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);
endmodule

bind nan_fma_select fmanan_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_infzero (in_infzero),
  .cfg_policy (cfg_policy),
  .cfg_dnan   (cfg_dnan),
  .cfg_legacy (cfg_legacy),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_code   (out_code),
  .out_res    (out_res),
  .inv_flag   (inv_flag)
);

// File: tb/tb_nan_fma_select.sv
module tb_nan_fma_select;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0;
  logic in_infzero = 1'b0;
  logic [1:0] cfg_policy = 2'd0;
  logic cfg_dnan = 1'b0, cfg_legacy = 1'b0;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] out_code;
  logic [31:0] out_res;
  logic inv_flag;

  always #(CLK_P/2) clk = ~clk;

  nan_fma_select dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_infzero(in_infzero),
    .cfg_policy(cfg_policy), .cfg_dnan(cfg_dnan), .cfg_legacy(cfg_legacy),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_res(out_res), .inv_flag(inv_flag)
  );

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic        m_valid = 1'b0, m_flag = 1'b0;
  logic [1:0]  m_code = '0;
  logic [31:0] m_res = '0;
  string       m_tag = "";

  localparam logic [31:0] QA = 32'h7FC0_0011, QB = 32'h7FC0_0022, QC = 32'hFFC0_0033;
  localparam logic [31:0] SA = 32'h7F80_0101, SB = 32'h7F80_0202, SC = 32'hFF80_0303;
  localparam logic [31:0] NUM = 32'h3F80_0000, INF = 32'h7F80_0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic void ref_cls(input logic [31:0] x, input logic leg,
                                  output bit q, output bit s);
    bit isnan, hi;
    isnan = (x[30:23] == 8'hFF) && (x[22:0] != 0);
    hi = x[22];
    q = isnan && (leg ? !hi : hi);
    s = isnan && (leg ? hi : !hi);
  endfunction

  function automatic logic [31:0] ref_dflt(input logic leg);
    return leg ? 32'h7FBF_FFFF : 32'h7FC0_0000;
  endfunction

  task automatic ref_eval(input logic [31:0] a, b, c, input logic iz,
                          input logic [1:0] pol, input logic dn, leg,
                          output logic [1:0] code, output logic [31:0] res,
                          output bit raise);
    bit qa, sa, qb, sb, qc, sc;
    logic [31:0] x;
    bit xq, xs;
    ref_cls(a, leg, qa, sa);
    ref_cls(b, leg, qb, sb);
    ref_cls(c, leg, qc, sc);
    raise = sa || sb || sc;
    case (pol)
      2'd0: if (iz && qc) begin code = 3; raise = 1; end
            else code = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
      2'd1: if (iz) begin code = 3; raise = 1; end
            else if (leg) code = sa ? 0 : sb ? 1 : sc ? 2 : qa ? 0 : qb ? 1 : 2;
            else code = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
      2'd2: if (iz) begin code = 2; raise = 1; end
            else code = (qa || sa) ? 0 : (qc || sc) ? 2 : 1;
      default: code = (qa || sa) ? 0 : (qb || sb) ? 1 : 2;
    endcase
    if (dn || code == 3) res = ref_dflt(leg);
    else begin
      x = (code == 0) ? a : (code == 1) ? b : c;
      ref_cls(x, leg, xq, xs);
      if (xs) res = leg ? ref_dflt(leg) : (x | 32'h0040_0000);
      else res = x;
    end
  endtask

  task automatic compare();
    chk(out_valid === m_valid, "R11", "out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    if (m_valid && out_valid) begin
      chk(out_code === m_code, m_tag, "out_code", {30'b0, out_code}, {30'b0, m_code});
      chk(out_res === m_res, m_tag, "out_res", out_res, m_res);
    end
    chk(inv_flag === m_flag, "R3", "inv_flag", {31'b0, inv_flag}, {31'b0, m_flag});
  endtask

  task automatic cycle(input logic v, input logic [31:0] a, b, c, input logic iz,
                       input logic [1:0] pol, input logic dn, leg, input logic rdy,
                       input string tag, output bit acc);
    logic old_v;
    logic [1:0] code;
    logic [31:0] res;
    bit raise;
    @(negedge clk);
    compare();
    old_v = m_valid;
    in_valid = v; in_a = a; in_b = b; in_c = c; in_infzero = iz;
    cfg_policy = pol; cfg_dnan = dn; cfg_legacy = leg; out_ready = rdy;
    acc = v && (!old_v || rdy);
    if (acc) begin
      ref_eval(a, b, c, iz, pol, dn, leg, code, res, raise);
      m_valid = 1'b1; m_code = code; m_res = res; m_tag = tag;
      m_flag = m_flag | raise;
    end else if (rdy) m_valid = 1'b0;
    #1;
    chk(in_ready === (!old_v || rdy), "R11", "in_ready", {31'b0, in_ready}, {31'b0, !old_v || rdy});
  endtask

  task automatic push(input logic [31:0] a, b, c, input logic iz, input logic [1:0] pol,
                      input logic dn, leg, input string tag);
    bit acc;
    acc = 0;
    while (!acc) cycle(1'b1, a, b, c, iz, pol, dn, leg, 1'b1, tag, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, '0, '0, '0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, "R11", acc);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, got %0d expected 0", 1);
    n_chk++; n_fail++;
    summary();
    $finish;
  end

  logic [31:0] pool [10];

  initial begin
    bit acc;
    pool[0] = QA; pool[1] = QB; pool[2] = QC; pool[3] = SA; pool[4] = SB;
    pool[5] = SC; pool[6] = NUM; pool[7] = INF; pool[8] = 32'h7FA0_0000; pool[9] = 32'h0000_0000;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid === 1'b0, "R12", "out_valid", {31'b0, out_valid}, 32'd0);
    chk(inv_flag === 1'b0, "R12", "inv_flag", {31'b0, inv_flag}, 32'd0);
    rst_n = 1'b1;

    // R1: infinity is not a NaN, no invalid raised
    push(INF, QB, NUM, 0, 2'd3, 0, 0, "R1");
    // R8: default policy, signaling a is quieted (R9)
    push(SA, QB, QC, 1, 2'd3, 0, 0, "R8");
    // R5: b signaling outranks c quiet
    push(QA, SB, QC, 0, 2'd0, 0, 0, "R5");
    push(SA, SB, SC, 0, 2'd0, 0, 0, "R5");
    // R4: infzero with quiet c, then with signaling c
    push(NUM, INF, QC, 1, 2'd0, 0, 0, "R4");
    push(NUM, INF, SC, 1, 2'd0, 0, 0, "R4");
    // R6: policy 1 orders per encoding, and infzero
    push(SA, NUM, SC, 0, 2'd1, 0, 0, "R6");
    push(QA, SB, QC, 0, 2'd1, 0, 0, "R6");
    push(32'h7FC0_0011, NUM, 32'h7FC0_0022, 0, 2'd1, 0, 1, "R6");
    push(NUM, NUM, QC, 1, 2'd1, 0, 0, "R6");
    // R7: policy 2
    push(NUM, INF, QC, 1, 2'd2, 0, 0, "R7");
    push(NUM, QB, QC, 0, 2'd2, 0, 0, "R7");
    push(NUM, QB, NUM, 0, 2'd2, 0, 0, "R7");
    // R2: legacy encoding classification and quieting
    push(32'h7F80_0101, NUM, NUM, 0, 2'd3, 0, 1, "R2");
    push(NUM, 32'h7FC0_0011, NUM, 0, 2'd3, 0, 1, "R2");
    // R9: code 3 in legacy gives legacy default NaN
    push(NUM, NUM, 32'h7F80_0101, 1, 2'd0, 0, 1, "R9");
    // R10: default NaN override, both encodings
    push(QA, NUM, NUM, 0, 2'd3, 1, 0, "R10");
    push(32'h7F80_0101, NUM, NUM, 0, 2'd3, 1, 1, "R10");
    idle(2);

    // R12: sticky flag cleared only by reset
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    m_valid = 1'b0; m_flag = 1'b0;
    repeat (2) @(negedge clk);
    chk(inv_flag === 1'b0, "R12", "inv_flag after reset", {31'b0, inv_flag}, 32'd0);
    chk(out_valid === 1'b0, "R12", "out_valid after reset", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;

    // R11: random stream with back-pressure
    for (int i = 0; i < 400; i++) begin
      cycle(($urandom % 4) != 0, pool[$urandom % 10], pool[$urandom % 10], pool[$urandom % 10],
            ($urandom % 5) == 0, 2'($urandom % 4), ($urandom % 6) == 0, ($urandom % 3) == 0,
            ($urandom % 5) < 3, "R11", acc);
    end
    idle(3);
    summary();
    $finish;
  end
endmodule